// File: doc/BRIEF.md
# Clock Frequency Window Monitor

This block watches the main logic clock of a motor-control chip using a slow, free-running reference oscillator that does not depend on the main clock. The reference is brought into the main clock domain. Each reference period is then measured as a count of main-clock cycles. The finished count is compared against a programmable lower and upper limit. A count outside that window means the main clock is too slow or too fast, and a latched fault is raised.

A fast clock matters as much as a slow one. A clock that runs too fast would shorten the dead time between high-side and low-side switching. For that reason the fault also withdraws the system enable, which the bridge logic uses to switch the power stage off.

The enable is further held low until the PLL reports lock. If lock never arrives, the enable stays low for good. A reference that stops entirely shows up as a counter that reaches its ceiling, and that is reported as a fault as well. The fault stays set until software pulses the clear input.

Top module: `clk_window_monitor`

## Requirements
- R1: While reset is asserted and on the first cycle after it, clkFail and sysEnable are both 0.
- R2: sysEnable is 0 whenever pllLocked (sampled on clk) was 0 at the previous rising edge. Once pllLocked is 1 and no fault is latched, sysEnable becomes 1 after the next rising edge.
- R3: The measured value is the number of clk rising edges between two consecutive rising edges of refClkIn. A value inside the inclusive window [minLimit, maxLimit] raises no fault.
- R4: A measured value greater than maxLimit sets clkFail.
- R5: A measured value less than minLimit sets clkFail.
- R6: The first reference period after reset, which starts from reset rather than from a reference edge, is never compared.
- R7: If no reference rising edge arrives before the cycle counter reaches 2^CNT_W-1 (1023 with defaults), clkFail is set. It keeps being set while the reference stays stopped.
- R8: clkFail stays 1 until clearFail is 1 at a rising edge. A clear is overridden when a fault condition is present at the same edge.
- R9: While clkFail is 1, sysEnable is 0. The two change at the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main logic clock under test |
| rst_n | input | 1 | Active-low reset, synchronous to clk |
| refClkIn | input | 1 | Slow reference oscillator, asynchronous to clk |
| pllLocked | input | 1 | PLL lock status, synchronous to clk |
| minLimit | input | CNT_W | Lowest accepted cycles per reference period |
| maxLimit | input | CNT_W | Highest accepted cycles per reference period |
| clearFail | input | 1 | Clears the latched fault when high at a clk edge |
| clkFail | output | 1 | Latched clock fault |
| sysEnable | output | 1 | Permission to run the power stage |

## Verification
A reference rising edge is seen by the fault flag on the fourth clk edge after it: two synchronizer stages, one capture edge and one evaluation edge. The bench therefore checks a window result only after the reference has been held low for many cycles past its last edge. Clear, lock and lock-loss act on the next clk edge, so those checks are sampled at the falling edge that follows that single edge. A stopped reference is detected 2^CNT_W-1 cycles after the last counter restart plus one edge, and the stall check waits well beyond that point. Inputs change and outputs are sampled only on falling clock edges.

// File: rtl/cwm_pkg.sv
package cwm_pkg;

  // Strobes issued by the control toward the datapath
  typedef struct packed {
    logic restart;   // reload the period counter
    logic capture;   // store the finished count
    logic evaluate;  // the stored count is valid for comparison
  } cwmStrobe_t;

  // Status returned by the datapath to the control
  typedef struct packed {
    logic aboveMax;
    logic belowMin;
    logic saturated;
  } cwmStatus_t;

endpackage

// File: rtl/cwm_ref_sync.sv
module cwm_ref_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic refAsync,
  output logic refRise
);

  logic [SYNC_STAGES-1:0] refPipe;
  logic                   refPrev;

  // Multi-flop synchronizer built stage by stage
  generate
    for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rst_n) refPipe[0] <= 1'b0;
          else        refPipe[0] <= refAsync;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rst_n) refPipe[s] <= 1'b0;
          else        refPipe[s] <= refPipe[s-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) refPrev <= 1'b0;
    else        refPrev <= refPipe[SYNC_STAGES-1];
  end

  assign refRise = refPipe[SYNC_STAGES-1] & ~refPrev;

  // R3: one reference edge yields exactly one single-cycle pulse
  a_r3_rise_single: assert property (@(posedge clk) disable iff (!rst_n)
    refRise |=> !refRise);

endmodule

// File: rtl/cwm_datapath.sv
module cwm_datapath
  import cwm_pkg::*;
#(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  cwmStrobe_t       strb,
  input  logic [CNT_W-1:0] minLimit,
  input  logic [CNT_W-1:0] maxLimit,
  output cwmStatus_t       dpStat
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [CNT_W-1:0] cycleCount;
  logic [CNT_W-1:0] lastCount;
  logic             atCeiling;

  assign atCeiling = (cycleCount == CNT_MAX);

  // Period counter: reload to one on restart, hold at the ceiling
  always_ff @(posedge clk) begin
    if (!rst_n)            cycleCount <= '0;
    else if (strb.restart) cycleCount <= CNT_ONE;
    else if (!atCeiling)   cycleCount <= cycleCount + CNT_ONE;
  end

  // Capture register for the finished period
  always_ff @(posedge clk) begin
    if (!rst_n)            lastCount <= '0;
    else if (strb.capture) lastCount <= cycleCount;
  end

  always_comb begin
    dpStat.aboveMax  = (lastCount > maxLimit);
    dpStat.belowMin  = (lastCount < minLimit);
    dpStat.saturated = atCeiling;
  end

  // R3: a restart makes the next count exactly one
  a_r3_restart_loads_one: assert property (@(posedge clk) disable iff (!rst_n)
    strb.restart |=> (cycleCount == CNT_ONE));

  // R7: the counter sticks at its ceiling until a restart
  a_r7_ceiling_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (atCeiling && !strb.restart) |=> (cycleCount == CNT_MAX));

endmodule

// File: rtl/cwm_control.sv
module cwm_control
  import cwm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       refRise,
  input  logic       pllLocked,
  input  logic       clearFail,
  input  cwmStatus_t dpStat,
  output cwmStrobe_t strb,
  output logic       clkFail,
  output logic       sysEnable
);

  logic armed;
  logic evalPending;
  logic windowFault;
  logic failNext;

  // The first edge after reset only arms the comparison
  always_ff @(posedge clk) begin
    if (!rst_n) armed <= 1'b0;
    else if (refRise) armed <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) evalPending <= 1'b0;
    else        evalPending <= refRise & armed;
  end

  always_comb begin
    strb.restart  = refRise;
    strb.capture  = refRise;
    strb.evaluate = evalPending;
  end

  assign windowFault = evalPending & (dpStat.aboveMax | dpStat.belowMin);
  assign failNext    = (clkFail & ~clearFail) | windowFault | dpStat.saturated;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      clkFail   <= 1'b0;
      sysEnable <= 1'b0;
    end else begin
      clkFail   <= failNext;
      sysEnable <= pllLocked & ~failNext;
    end
  end

  // R2: no lock at an edge means no enable after it
  a_r2_lock_gates_enable: assert property (@(posedge clk) disable iff (!rst_n)
    !pllLocked |=> !sysEnable);

  // R8: the fault stays while no clear is applied
  a_r8_fail_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (clkFail && !clearFail) |=> clkFail);

  // R7: a saturated counter always yields a fault
  a_r7_stall_sets_fail: assert property (@(posedge clk) disable iff (!rst_n)
    dpStat.saturated |=> clkFail);

  // R4, R5: a new fault comes only from an evaluation or a stall
  a_r5_fail_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clkFail) |-> ($past(strb.evaluate) || $past(dpStat.saturated)));

endmodule

// File: rtl/clk_window_monitor.sv
module clk_window_monitor
  import cwm_pkg::*;
#(
  parameter int CNT_W       = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             refClkIn,
  input  logic             pllLocked,
  input  logic [CNT_W-1:0] minLimit,
  input  logic [CNT_W-1:0] maxLimit,
  input  logic             clearFail,
  output logic             clkFail,
  output logic             sysEnable
);

  logic       refRise;
  cwmStrobe_t strb;
  cwmStatus_t dpStat;

  cwm_ref_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .refAsync (refClkIn),
    .refRise  (refRise)
  );

  cwm_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .strb     (strb),
    .minLimit (minLimit),
    .maxLimit (maxLimit),
    .dpStat   (dpStat)
  );

  cwm_control u_ctl (
    .clk       (clk),
    .rst_n     (rst_n),
    .refRise   (refRise),
    .pllLocked (pllLocked),
    .clearFail (clearFail),
    .dpStat    (dpStat),
    .strb      (strb),
    .clkFail   (clkFail),
    .sysEnable (sysEnable)
  );

endmodule

// File: tb/clk_window_monitor_tb.sv
module clk_window_monitor_tb;

  localparam int CNT_W   = 10;
  localparam int NUM_VEC = 8;
  // period, minLimit, maxLimit, expected clkFail
  localparam int VEC_TAB [NUM_VEC][4] = '{
    '{100, 90, 110, 0},
    '{120, 90, 110, 1},
    '{ 80, 90, 110, 1},
    '{110, 90, 110, 0},
    '{ 90, 90, 110, 0},
    '{111, 90, 110, 1},
    '{ 89, 90, 110, 1},
    '{ 50, 40,  60, 0}
  };

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             refClkIn = 1'b0;
  logic             pllLocked = 1'b0;
  logic [CNT_W-1:0] minLimit = '0;
  logic [CNT_W-1:0] maxLimit = '1;
  logic             clearFail = 1'b0;
  logic             clkFail;
  logic             sysEnable;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  clk_window_monitor #(.CNT_W(CNT_W)) u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .refClkIn  (refClkIn),
    .pllLocked (pllLocked),
    .minLimit  (minLimit),
    .maxLimit  (maxLimit),
    .clearFail (clearFail),
    .clkFail   (clkFail),
    .sysEnable (sysEnable)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !finished) begin
      bad++;
      total++;
      $display("FAIL watchdog: run hung, actual=running expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic check(string req, logic act, logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic doReset();
    refClkIn = 1'b0;
    clearFail = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic runRef(int period, int n);
    for (int k = 0; k < n; k++) begin
      refClkIn = 1'b1;
      repeat (period / 2) @(negedge clk);
      refClkIn = 1'b0;
      repeat (period - period / 2) @(negedge clk);
    end
  endtask

  task automatic pulseClear();
    clearFail = 1'b1;
    @(negedge clk);
    clearFail = 1'b0;
  endtask

  initial begin
    // R1: reset state
    @(negedge clk);
    check("R1 fail in reset", clkFail, 1'b0);
    check("R1 enable in reset", sysEnable, 1'b0);
    doReset();
    check("R1 fail after reset", clkFail, 1'b0);
    check("R1 enable after reset", sysEnable, 1'b0);

    // R3/R4/R5/R6: window table
    for (int v = 0; v < NUM_VEC; v++) begin
      minLimit  = CNT_W'(VEC_TAB[v][1]);
      maxLimit  = CNT_W'(VEC_TAB[v][2]);
      pllLocked = 1'b1;
      doReset();
      runRef(VEC_TAB[v][0], 4);
      repeat (6) @(negedge clk);
      check($sformatf("R3 R4 R5 R6 vector %0d period %0d", v, VEC_TAB[v][0]),
            clkFail, VEC_TAB[v][3] != 0);
      check($sformatf("R9 enable vector %0d", v), sysEnable, VEC_TAB[v][3] == 0);
    end

    // R6: a short first gap after reset is not compared
    minLimit = 10'd90; maxLimit = 10'd110; pllLocked = 1'b1;
    doReset();
    repeat (2) @(negedge clk);
    runRef(100, 1);
    repeat (6) @(negedge clk);
    check("R6 first period ignored", clkFail, 1'b0);

    // R2: enable follows lock
    pllLocked = 1'b0;
    doReset();
    runRef(100, 3);
    check("R2 no enable without lock", sysEnable, 1'b0);
    pllLocked = 1'b1;
    @(negedge clk);
    check("R2 enable after lock", sysEnable, 1'b1);
    pllLocked = 1'b0;
    @(negedge clk);
    check("R2 enable drops with lock", sysEnable, 1'b0);
    pllLocked = 1'b1;
    @(negedge clk);

    // R8: sticky fault and clear
    runRef(130, 2);
    repeat (6) @(negedge clk);
    check("R4 slow-count fault", clkFail, 1'b1);
    repeat (20) @(negedge clk);
    check("R8 fault held", clkFail, 1'b1);
    check("R9 enable low while fault", sysEnable, 1'b0);
    pulseClear();
    check("R8 fault cleared", clkFail, 1'b0);
    check("R9 enable back after clear", sysEnable, 1'b1);

    // R7: stopped reference
    doReset();
    runRef(100, 3);
    check("R7 no fault before stall", clkFail, 1'b0);
    repeat (1100) @(negedge clk);
    check("R7 stalled reference fault", clkFail, 1'b1);
    check("R9 enable low on stall", sysEnable, 1'b0);
    pulseClear();
    check("R8 clear overridden by stall", clkFail, 1'b1);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule